// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches thirteen general-purpose input pins, split into a low group of eight (pins 0 to 7) and a high group of five (pins 8 to 12). It raises one interrupt request per group when any selected pin in that group changes level. Each pin has its own select bit in a per-group mask register. Each group has an enable bit in a shared control register. A single pending flag per group records that a qualifying change has occurred.

Each pin passes through a two-flop synchronizer. A change is a difference between the synchronized level and the level one cycle earlier, so both rising and falling edges count. The request output of a group is the group's pending flag gated by its group enable and by a global interrupt-enable input. Software clears a pending flag by writing a one to its bit. The flag also clears when the processor acknowledges that group's vector. If a new change arrives in the same cycle as a clear, the flag stays set.

Registers are reached through a simple port: a write strobe with address and data, and a combinational read of the addressed register.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, the control, flag and both mask registers read 0x00 and both request outputs are low.
- R2: A level change in either direction on a pin whose mask bit and group enable are set makes that group's flag read 1. The flag becomes readable on the third rising clock edge after the pin is driven, and not earlier.
- R3: A change on a pin whose mask bit is 0 leaves the group flag unchanged.
- R4: A change on a selected pin while its group enable (control bit g) is 0 leaves the group flag unchanged.
- R5: Request output g is high exactly when flag g, control bit g and the global interrupt-enable input are all 1.
- R6: Writing the flag register (address 0x3B, bit g = group g) clears each flag whose written bit is 1 and leaves the flags written with 0 unchanged.
- R7: A one-cycle acknowledge on ack_i[g] clears flag g at that clock edge.
- R8: When a qualifying change and a clear (acknowledge or write-one) fall on the same edge, the flag ends up set.
- R9: The register map is: control at 0x68 (bits 1:0 are the group enables, bits 7:2 read 0), flag at 0x3B (bits 7:2 read 0), low-group mask at 0x6B (all 8 bits read/write), high-group mask at 0x6C (bits 4:0 read/write, bits 7:5 always read 0). Any other address reads 0x00.
- R10: Pins 0 to 7 affect only flag 0, and pins 8 to 12 affect only flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 13 | Asynchronous pin levels; bit n is pin n |
| global_ie_i | input | 1 | Global interrupt enable from the processor |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, applied at the rising edge |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |
| ack_i | input | 2 | Per-group vector acknowledge, one-cycle pulse |
| irq_o | output | 2 | Per-group interrupt request |

## Verification
A pin change is due in the flag three rising edges after it is driven: two synchronizer stages, then the flag register. The bench drives pins at a falling edge and reads the flag after exactly two falling edges, expecting 0. It reads again after the third, expecting 1. A register write or an acknowledge takes effect at the single rising edge that follows the falling edge where it is driven, so the bench reads back at the next falling edge. The request output follows the flag and enables combinationally, so it is sampled in the same half-cycle as the flag read. For the set-over-clear case, the acknowledge is placed in the cycle where the change is visible past the second synchronizer stage, so both land on the same edge.

// File: rtl/pcint_pkg.sv
// Package: shared address map and sizes for the pin-change interrupt block.
// Assumes an 8-bit register bus and exactly two pin groups.
package pcint_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int NGROUPS = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h68;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 8'h3B;
    localparam logic [ADDR_W-1:0] ADDR_MSK0 = 8'h6B;
    localparam logic [ADDR_W-1:0] ADDR_MSK1 = 8'h6C;
endpackage

// File: rtl/pin_sync_edge.sv
// Module: two-flop synchronizer plus change detector for a vector of pins.
// Assumes pins are asynchronous to clk. chg_o is high for one cycle when the
// synchronized level differs from its value one cycle earlier.
module pin_sync_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] chg_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Synchronize the pins and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pins_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign chg_o = sync_q ^ prev_q;
endmodule

// File: rtl/pc_group_flag.sv
// Module: pending flag for one pin group.
// Assumes chg_i comes from a synchronizer. A masked change with the group
// enabled sets the flag. A write-one or an acknowledge clears it; a set on
// the same edge as a clear wins.
module pc_group_flag #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] chg_i,
    input  logic [W-1:0] mask_i,
    input  logic         grp_en_i,
    input  logic         clr_wr_i,
    input  logic         ack_i,
    output logic         flag_o
);
    logic hit;
    logic flag_q;

    assign hit = grp_en_i & (|(chg_i & mask_i));

    // Hold the pending flag: set has priority over both clear sources.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (clr_wr_i || ack_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R2
    flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(hit));
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);
    // R6
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !hit) |=> !flag_q);
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !hit) |=> !flag_q);
endmodule

// File: rtl/pin_change_irq.sv
// Module: grouped pin-change interrupt controller (top).
// Assumes each group holds at most DATA_W pins, writes take effect at the
// rising edge with we_i high, and reads are combinational on addr_i.
module pin_change_irq
    import pcint_pkg::*;
#(
    parameter int G0_PINS = 8,
    parameter int G1_PINS = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [G0_PINS+G1_PINS-1:0]     pins_i,
    input  logic                           global_ie_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic                           we_i,
    output logic [DATA_W-1:0]              rdata_o,
    input  logic [NGROUPS-1:0]             ack_i,
    output logic [NGROUPS-1:0]             irq_o
);
    localparam int NPINS = G0_PINS + G1_PINS;

    logic [NPINS-1:0]               chg_w;
    logic [NGROUPS-1:0]             ctrl_q;
    logic [NGROUPS-1:0]             flag_w;
    logic [NGROUPS-1:0][DATA_W-1:0] mask_rd;
    logic                           flag_wr;

    assign flag_wr = we_i && (addr_i == ADDR_FLAG);

    pin_sync_edge #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .chg_o  (chg_w)
    );

    // Store the group enable bits of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we_i && addr_i == ADDR_CTRL)
            ctrl_q <= wdata_i[NGROUPS-1:0];
    end

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        localparam int                 W     = (g == 0) ? G0_PINS : G1_PINS;
        localparam int                 LO    = (g == 0) ? 0 : G0_PINS;
        localparam logic [ADDR_W-1:0]  MADDR = (g == 0) ? ADDR_MSK0 : ADDR_MSK1;

        logic [W-1:0] msk_q;

        // Store this group's per-pin select mask.
        always_ff @(posedge clk) begin
            if (!rst_n)
                msk_q <= '0;
            else if (we_i && addr_i == MADDR)
                msk_q <= wdata_i[W-1:0];
        end

        assign mask_rd[g] = DATA_W'(msk_q);

        pc_group_flag #(.W(W)) u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .chg_i    (chg_w[LO +: W]),
            .mask_i   (msk_q),
            .grp_en_i (ctrl_q[g]),
            .clr_wr_i (flag_wr && wdata_i[g]),
            .ack_i    (ack_i[g]),
            .flag_o   (flag_w[g])
        );

        assign irq_o[g] = flag_w[g] & ctrl_q[g] & global_ie_i;
    end

    // Select the addressed register for readback; unused bits read 0.
    always_comb begin
        case (addr_i)
            ADDR_CTRL: rdata_o = DATA_W'(ctrl_q);
            ADDR_FLAG: rdata_o = DATA_W'(flag_w);
            ADDR_MSK0: rdata_o = mask_rd[0];
            ADDR_MSK1: rdata_o = mask_rd[1];
            default:   rdata_o = '0;
        endcase
    end

    // R5
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> global_ie_i);
    // R9
    msk1_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_MSK1) |-> ((rdata_o >> G1_PINS) == '0));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq_o == '0));
endmodule

// File: tb/pin_change_irq_tb_top.sv
module pin_change_irq_tb_top;
    import pcint_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] pins_i = '0;
    logic        global_ie_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        we_i = 1'b0;
    logic [7:0]  rdata_o;
    logic [1:0]  ack_i = '0;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pin_change_irq dut_i (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .global_ie_i(global_ie_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o),
        .ack_i(ack_i), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; we_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic flip_pin(input int n);
        @(negedge clk);
        pins_i[n] = ~pins_i[n];
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(ADDR_CTRL, v); check("R1 ctrl", v, 8'h00);
        rd(ADDR_FLAG, v); check("R1 flag", v, 8'h00);
        rd(ADDR_MSK0, v); check("R1 msk0", v, 8'h00);
        rd(ADDR_MSK1, v); check("R1 msk1", v, 8'h00);
        check("R1 irq", {6'd0, irq_o}, 8'h00);
    endtask

    task automatic t_rise_timing();
        logic [7:0] v;
        wr(ADDR_CTRL, 8'h03);
        wr(ADDR_MSK0, 8'h01);
        global_ie_i = 1'b1;
        flip_pin(0);
        wait_neg(2);
        rd(ADDR_FLAG, v); check("R2 not yet", v, 8'h00);
        wait_neg(1);
        rd(ADDR_FLAG, v); check("R2 rise set", v, 8'h01);
        check("R5 irq0 high", {6'd0, irq_o}, 8'h01);
        check("R10 g1 quiet", {7'd0, irq_o[1]}, 8'h00);
    endtask

    task automatic t_write_clear();
        logic [7:0] v;
        wr(ADDR_FLAG, 8'h00);
        rd(ADDR_FLAG, v); check("R6 zero keeps", v, 8'h01);
        wr(ADDR_FLAG, 8'h01);
        rd(ADDR_FLAG, v); check("R6 one clears", v, 8'h00);
        check("R5 irq low", {6'd0, irq_o}, 8'h00);
    endtask

    task automatic t_fall_and_ack();
        logic [7:0] v;
        flip_pin(0);
        wait_neg(3);
        rd(ADDR_FLAG, v); check("R2 fall set", v, 8'h01);
        ack_i = 2'b01;
        @(negedge clk);
        ack_i = 2'b00;
        rd(ADDR_FLAG, v); check("R7 ack clears", v, 8'h00);
    endtask

    task automatic t_mask_off();
        logic [7:0] v;
        flip_pin(1);
        wait_neg(4);
        rd(ADDR_FLAG, v); check("R3 masked pin", v, 8'h00);
    endtask

    task automatic t_group_disable();
        logic [7:0] v;
        wr(ADDR_MSK1, 8'h1F);
        wr(ADDR_CTRL, 8'h01);
        flip_pin(8);
        wait_neg(4);
        rd(ADDR_FLAG, v); check("R4 group off", v, 8'h00);
        wr(ADDR_CTRL, 8'h03);
        flip_pin(9);
        wait_neg(3);
        rd(ADDR_FLAG, v); check("R10 g1 only", v, 8'h02);
        global_ie_i = 1'b0;
        #1;
        check("R5 gie off", {6'd0, irq_o}, 8'h00);
        global_ie_i = 1'b1;
        #1;
        check("R5 gie on", {6'd0, irq_o}, 8'h02);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(ADDR_MSK1, 8'hFF);
        rd(ADDR_MSK1, v); check("R9 msk1 upper", v, 8'h1F);
        wr(ADDR_MSK0, 8'hA5);
        rd(ADDR_MSK0, v); check("R9 msk0 full", v, 8'hA5);
        wr(ADDR_CTRL, 8'hFF);
        rd(ADDR_CTRL, v); check("R9 ctrl upper", v, 8'h03);
        rd(8'h00, v); check("R9 unmapped", v, 8'h00);
        rd(ADDR_FLAG, v); check("R9 flag upper", v, 8'h02);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        flip_pin(10);
        wait_neg(2);
        ack_i = 2'b10;
        @(negedge clk);
        ack_i = 2'b00;
        rd(ADDR_FLAG, v); check("R8 set beats ack", v, 8'h02);
        ack_i = 2'b10;
        @(negedge clk);
        ack_i = 2'b00;
        rd(ADDR_FLAG, v); check("R7 ack g1", v, 8'h00);
    endtask

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise_timing();
        t_write_clear();
        t_fall_and_ack();
        t_mask_off();
        t_group_disable();
        t_regmap();
        t_set_wins();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule